// File: doc/BRIEF.md
# Masked vector expand unit

This unit spreads packed 64-bit words from a source vector into lane-mask-chosen lanes of a destination vector. The source words are used in order from the lowest one upward. Walking the destination lanes from lane 0 upward, each chosen lane takes the next unused source word. Each lane that is not chosen either keeps its old destination value or is cleared, depending on a zeroing select.

A length code picks how many of the eight 64-bit lanes are active. Everything above the active length is cleared. A 4-bit reserved operand field must be all ones. Any other value raises a fault, and the destination output then keeps its previous value. Each operation enters through a valid/ready handshake. The registered result is held until the consumer takes it.

Top module: `vexp_unit`

## Requirements
- R1: The length code `vlen` sets the active lane count: 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), and 2 or 3 give 8 lanes (512 bits). Lane j occupies bits [64j+63:64j].
- R2: Active lanes are visited in ascending order. A selected lane j receives source word number c, where c is the number of selected lanes below j.
- R3: With `mask_en` low, every active lane counts as selected, so the active lanes hold a straight copy of the lowest source words.
- R4: An active lane that is not selected keeps its `old_dst` value when `zero_mode` is 0, and becomes zero when `zero_mode` is 1.
- R5: All result bits above the active length, up to bit 511, are zero, whatever the mask, the mode or `old_dst`.
- R6: When `rsv_field` is not 4'b1111, `out_fault` is 1 and `out_dst` keeps the value it had before the operation. When `rsv_field` is 4'b1111, `out_fault` is 0.
- R7: Mask bits at lane positions at or above the active lane count have no effect. Source words beyond the number of selected lanes have no effect.
- R8: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. On the next edge `out_valid` rises with the result. The result stays stable while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_fault` and `out_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| src | input | 512 | Packed source words, word 0 lowest |
| old_dst | input | 512 | Previous destination value |
| lane_mask | input | 8 | Per-lane select, bit j for lane j |
| mask_en | input | 1 | 1 applies lane_mask, 0 selects all active lanes |
| zero_mode | input | 1 | 1 clears unselected lanes, 0 keeps old value |
| vlen | input | 2 | Length code: 0=128, 1=256, 2/3=512 bits |
| rsv_field | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_dst | output | 512 | New destination value |
| out_fault | output | 1 | Reserved field was not all ones |

## Verification
A wrong running source index shows on the first result after the faulty selected lane. Every higher selected lane then carries a shifted source word, so random sparse masks reveal it one cycle after the handshake. A wrong active-lane decode or a wrong merge choice appears in that same result as stray data above the active length, or as old and zero values in the wrong lanes. A lost hold or a bad fault gate shows on the cycle after the stall or the faulting accept, as a changed `out_dst`.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  localparam int VLEN_CODE_W = 2;

  typedef enum logic [VLEN_CODE_W-1:0] {
    LEN_SHORT = 2'd0,
    LEN_MID   = 2'd1,
    LEN_FULL  = 2'd2,
    LEN_FULL2 = 2'd3
  } len_code_e;
endpackage

// File: rtl/vexp_lane_sel.sv
module vexp_lane_sel #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]                    mask,
  input  logic                                mask_en,
  input  logic [vexp_pkg::VLEN_CODE_W-1:0]    vlen,
  output logic [LANES-1:0]                    active,
  output logic [LANES-1:0]                    sel
);
  import vexp_pkg::*;
  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] n_act;

  always_comb begin
    case (len_code_e'(vlen))
      LEN_SHORT: n_act = CNT_W'(LANES / 4);
      LEN_MID:   n_act = CNT_W'(LANES / 2);
      default:   n_act = CNT_W'(LANES);
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_act
    assign active[j] = (CNT_W'(j) < n_act);
  end

  assign sel = active & (mask_en ? mask : {LANES{1'b1}});
endmodule

// File: rtl/vexp_scatter.sv
module vexp_scatter #(
  parameter int LANE_W = 64,
  parameter int LANES  = 8
) (
  input  logic [LANE_W*LANES-1:0] src,
  input  logic [LANE_W*LANES-1:0] old_dst,
  input  logic [LANES-1:0]        active,
  input  logic [LANES-1:0]        sel,
  input  logic                    zero_mode,
  output logic [LANE_W*LANES-1:0] dst
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IDX_W-1:0] idx;

    always_comb begin
      idx = '0;
      for (int b = 0; b < j; b++) begin
        idx = idx + IDX_W'(sel[b]);
      end
    end

    always_comb begin
      if (!active[j])
        dst[j*LANE_W +: LANE_W] = '0;
      else if (sel[j])
        dst[j*LANE_W +: LANE_W] = src[idx*LANE_W +: LANE_W];
      else if (zero_mode)
        dst[j*LANE_W +: LANE_W] = '0;
      else
        dst[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/vexp_unit.sv
module vexp_unit #(
  parameter int LANE_W = 64,
  parameter int LANES  = 8,
  parameter int RSV_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [LANE_W*LANES-1:0]         src,
  input  logic [LANE_W*LANES-1:0]         old_dst,
  input  logic [LANES-1:0]                lane_mask,
  input  logic                            mask_en,
  input  logic                            zero_mode,
  input  logic [vexp_pkg::VLEN_CODE_W-1:0] vlen,
  input  logic [RSV_W-1:0]                rsv_field,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [LANE_W*LANES-1:0]         out_dst,
  output logic                            out_fault
);
  localparam int VEC_W = LANE_W * LANES;

  logic [LANES-1:0] active, sel;
  logic [VEC_W-1:0] next_dst;
  logic             accept, rsv_ok;

  vexp_lane_sel #(.LANES(LANES)) u_sel (
    .mask(lane_mask), .mask_en(mask_en), .vlen(vlen),
    .active(active), .sel(sel)
  );

  vexp_scatter #(.LANE_W(LANE_W), .LANES(LANES)) u_scat (
    .src(src), .old_dst(old_dst), .active(active), .sel(sel),
    .zero_mode(zero_mode), .dst(next_dst)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign rsv_ok   = (rsv_field == {RSV_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_dst   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_fault <= !rsv_ok;
      if (rsv_ok) out_dst <= next_dst;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_fault && out_dst == '0));

  assert_accept_valid_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dst) && $stable(out_fault)));

  assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && !rsv_ok) |=> (out_fault && $stable(out_dst)));

  assert_short_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && rsv_ok && vlen == 2'd0) |=> (out_dst[VEC_W-1:2*LANE_W] == '0));

  assert_nomask_copy_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && rsv_ok && !mask_en && vlen[1]) |=> (out_dst == $past(src)));
endmodule

// File: tb/vexp_unit_test.sv
`timescale 1ns/1ps
module vexp_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [511:0] src = '0, old_dst = '0, out_dst;
  logic [7:0] lane_mask = '0;
  logic mask_en = 1'b0, zero_mode = 1'b0;
  logic [1:0] vlen = 2'd0;
  logic [3:0] rsv_field = 4'hF;
  logic out_valid, out_ready = 1'b1, out_fault;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [511:0] last_dst = '0;

  always #2 clk = ~clk;

  vexp_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .old_dst(old_dst), .lane_mask(lane_mask), .mask_en(mask_en),
    .zero_mode(zero_mode), .vlen(vlen), .rsv_field(rsv_field),
    .out_valid(out_valid), .out_ready(out_ready), .out_dst(out_dst),
    .out_fault(out_fault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] model(logic [511:0] s, logic [511:0] o, logic [7:0] m,
                                         bit en, bit z, logic [1:0] vl);
    logic [511:0] r = '0;
    int n = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    int k = 0;
    for (int j = 0; j < 8; j++) begin
      if (j < n) begin
        if (!en || m[j]) begin
          r[j*64 +: 64] = s[k*64 +: 64];
          k++;
        end else if (!z) begin
          r[j*64 +: 64] = o[j*64 +: 64];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic issue(input logic [511:0] s, input logic [511:0] o, input logic [7:0] m,
                       input bit en, input bit z, input logic [1:0] vl, input logic [3:0] rsv,
                       input string tag);
    logic [511:0] exp;
    bit bad = (rsv != 4'hF);
    exp = bad ? last_dst : model(s, o, m, en, z, vl);
    @(negedge clk);
    src = s; old_dst = o; lane_mask = m; mask_en = en; zero_mode = z;
    vlen = vl; rsv_field = rsv; out_ready = 1'b1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " R8 out_valid after accept"}, 512'(out_valid), 512'(1));
    chk(out_fault == bad, {tag, " R6 fault flag"}, 512'(out_fault), 512'(bad));
    chk(out_dst == exp, {tag, " dst"}, out_dst, exp);
    last_dst = exp;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid, "R9 out_valid in reset", 512'(out_valid), 512'(0));
    chk(!out_fault, "R9 out_fault in reset", 512'(out_fault), 512'(0));
    chk(out_dst == '0, "R9 out_dst in reset", out_dst, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready, "R8 in_ready idle", 512'(in_ready), 512'(1));
  endtask

  task automatic t_nomask();
    logic [511:0] s = rnd512(), o = rnd512();
    issue(s, o, 8'h00, 0, 0, 2'd0, 4'hF, "R3 R1 R5 nomask vl128");
    chk(out_dst[511:128] == '0, "R5 above 128 zero", out_dst, '0);
    issue(s, o, 8'h00, 0, 1, 2'd1, 4'hF, "R3 R1 nomask vl256");
    issue(s, o, 8'h5A, 0, 0, 2'd2, 4'hF, "R3 nomask vl512");
    chk(out_dst == s, "R3 full copy", out_dst, s);
    issue(s, o, 8'h00, 0, 0, 2'd3, 4'hF, "R1 code3 is 512");
  endtask

  task automatic t_zero_mask();
    logic [511:0] s = rnd512(), o = rnd512();
    issue(s, o, 8'h00, 1, 0, 2'd2, 4'hF, "R4 allzero merge");
    chk(out_dst == o, "R4 merge keeps old", out_dst, o);
    issue(s, o, 8'h00, 1, 1, 2'd2, 4'hF, "R4 allzero zeroing");
    chk(out_dst == '0, "R4 zeroing clears", out_dst, '0);
    issue(s, o, 8'hFF, 1, 0, 2'd2, 4'hF, "R2 allones");
  endtask

  task automatic t_sparse();
    logic [511:0] s = rnd512(), o = rnd512();
    issue(s, o, 8'b1010_0101, 1, 0, 2'd2, 4'hF, "R2 sparse merge");
    chk(out_dst[2*64 +: 64] == s[1*64 +: 64], "R2 lane2 gets word1", out_dst, s);
    chk(out_dst[7*64 +: 64] == s[3*64 +: 64], "R2 lane7 gets word3", out_dst, s);
    chk(out_dst[1*64 +: 64] == o[1*64 +: 64], "R4 lane1 kept", out_dst, o);
    issue(s, o, 8'b0110_1000, 1, 1, 2'd1, 4'hF, "R2 R5 sparse vl256 zero");
  endtask

  task automatic t_ignored();
    logic [511:0] s = rnd512(), o = rnd512(), s2;
    issue(s, o, 8'hFC, 1, 1, 2'd0, 4'hF, "R7 high mask bits ignored");
    chk(out_dst == '0, "R7 no active lane selected", out_dst, '0);
    issue(s, o, 8'hFE, 1, 0, 2'd0, 4'hF, "R7 lane1 gets word0");
    chk(out_dst[64 +: 64] == s[63:0], "R7 lane1 word0", out_dst, s);
    s2 = s;
    s2[511:128] = rnd512();
    issue(s2, o, 8'b0001_0010, 1, 0, 2'd2, 4'hF, "R7 upper src ignored");
    issue(s, o, 8'b0001_0010, 1, 0, 2'd2, 4'hF, "R7 upper src ignored again");
  endtask

  task automatic t_fault();
    issue(rnd512(), rnd512(), 8'hFF, 1, 0, 2'd2, 4'hE, "R6 rsv E");
    issue(rnd512(), rnd512(), 8'h0F, 0, 1, 2'd1, 4'h0, "R6 rsv 0");
    issue(rnd512(), rnd512(), 8'h33, 1, 1, 2'd2, 4'hF, "R6 good clears fault");
  endtask

  task automatic t_backpressure();
    logic [511:0] s = rnd512(), o = rnd512(), exp, held;
    exp = model(s, o, 8'h96, 1, 0, 2'd2);
    @(negedge clk);
    src = s; old_dst = o; lane_mask = 8'h96; mask_en = 1; zero_mode = 0;
    vlen = 2'd2; rsv_field = 4'hF; out_ready = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    src = rnd512(); lane_mask = 8'hFF;
    chk(out_dst == exp, "R8 stalled result", out_dst, exp);
    chk(!in_ready, "R8 in_ready low while pending", 512'(in_ready), 512'(0));
    held = out_dst;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_dst == held, "R8 hold while stalled", out_dst, held);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    #0;
    chk(in_ready, "R8 in_ready with out_ready", 512'(in_ready), 512'(1));
    @(negedge clk);
    chk(!out_valid, "R8 valid drops after take", 512'(out_valid), 512'(0));
    chk(out_dst == exp, "R8 second offer not taken", out_dst, exp);
    last_dst = exp;
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      issue(rnd512(), rnd512(), 8'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), 4'hF, "R2 R4 random");
    end
  endtask

  initial begin
    void'($urandom(7));
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_nomask();
    t_zero_mask();
    t_sparse();
    t_ignored();
    t_fault();
    t_backpressure();
    t_random();
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule